// File: doc/BRIEF.md
# Serial Clock-Configuration Write Slave

This block is the configuration port of a clock generator. It listens on a two-wire serial bus (a clock line and an open-drain data line) and takes write transactions only. Each transaction opens with a start condition and sends a fixed device address. A command byte follows; the slave acknowledges it and then discards it. Next comes a byte count, then the data bytes. The data bytes fill a small register file in ascending order. Both bus lines pass through synchronizers into the block's own clock domain. The slave pulls the data line low only through `sda_oe`, and only while the bus clock is low.

Register 0 holds the frequency-select field and the other function controls. The frequency-select field sits in its low `FS_W` bits and drives `fs_sel`. Every later register holds eight output-enable bits. Each enable bit gates one clock input onto one output, so a disabled output stays low. During reset the frequency-select field loads the inverted levels of the strap pins.

The whole register file also appears on `reg_flat`, with register g at bits [g*8 +: 8]. All ports are plain control and status pins. There is no streaming interface, so there is no back-pressure to define.

Top module: `clkcfg_serial_slave`

## Requirements
- R1: While reset is held, register 0 loads `~fs_strap` in bits [FS_W-1:0] and zeros in its upper bits. Every other register loads 8'hFF, and `sda_oe` is 0.
- R2: After a start condition, an address byte equal to 8'hD2 (sent MSB first, bits sampled while the bus clock is high) is acknowledged: `sda_oe` is 1 for the whole ninth clock pulse.
- R3: Any other address byte gets no acknowledge. Until the next start condition, no later byte is acknowledged and no register changes.
- R4: The byte after a matching address is acknowledged and changes no register.
- R5: The third byte is acknowledged and sets the count N. The next N data bytes are acknowledged and written to registers 0, 1, 2, … in order.
- R6: Counted data bytes beyond register NUM_REGS-1 are acknowledged and discarded.
- R7: Once N data bytes have arrived, further bytes are not acknowledged and are discarded.
- R8: A stop condition returns the slave to idle. Bus clock pulses after it, with no start condition, are never acknowledged.
- R9: A start condition in the middle of a transaction (repeated start) abandons the pending count and begins a new address phase.
- R10: `sda_oe` changes only while the bus clock is low.
- R11: `clk_gated[i]` equals `clk_src[i]` AND bit (i mod 8) of register 1 + i/8, so it is held low while that enable bit is 0.
- R12: `fs_sel` always equals bits [FS_W-1:0] of register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the bus lines are oversampled by it |
| rst_n | input | 1 | Active-low asynchronous reset; strap pins are latched while it is low |
| scl | input | 1 | Serial bus clock |
| sda_in | input | 1 | Resolved level of the serial data line |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| fs_strap | input | FS_W | Strap pins giving the frequency-select default (inverted) |
| clk_src | input | (NUM_REGS-1)*8 | Clock inputs to be gated |
| reg_flat | output | NUM_REGS*8 | All configuration registers, register g at [g*8 +: 8] |
| fs_sel | output | FS_W | Frequency-select field of register 0 |
| clk_gated | output | (NUM_REGS-1)*8 | Gated clocks, low while disabled |

## Verification
Random transactions use random counts and random data lengths. Some send fewer bytes than the count and some send more, which separates the "beyond the register file" discard from the "beyond the count" discard. Directed cases cover a wrong address followed by more bytes, clock pulses after a stop with no start, and a repeated start in the middle of a count that is then followed by a wrong address. These show whether aborting a transaction really drops the pending count. Random clock-source patterns, compared against the modelled enable bytes, separate the gating of each bit from the register ordering.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BITS,
    ST_HOLD,
    ST_ACK,
    ST_IGNORE
  } rx_state_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_CNT,
    PH_DATA
  } rx_phase_t;
endpackage

// File: rtl/clkcfg_line_sync.sv
module clkcfg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic              scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_raw};
      sda_sh <= {sda_sh[STAGES-2:0], sda_raw};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_q     = scl_sh[STAGES-1];
  assign sda_q     = sda_sh[STAGES-1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign start_det = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;

  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_det && stop_det) && !(scl_rise && scl_fall)); // R9
endmodule

// File: rtl/clkcfg_rx.sv
module clkcfg_rx
  import clkcfg_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR = 8'hD2,
  parameter int         NUM_REGS = 4,
  localparam int        RIDX_W   = $clog2(NUM_REGS),
  localparam int        CNT_W    = $clog2(NUM_REGS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_q,
  input  logic              sda_q,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [RIDX_W-1:0] wr_idx,
  output logic [7:0]        wr_data
);
  localparam logic [CNT_W-1:0] IDX_END = CNT_W'(NUM_REGS);

  rx_state_t        state;
  rx_phase_t        phase;
  logic [2:0]       bitcnt;
  logic [7:0]       shreg;
  logic [7:0]       remain;
  logic [CNT_W-1:0] idx;
  logic             ack_pend;
  logic [7:0]       nb;

  assign nb = {shreg[6:0], sda_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      phase    <= PH_ADDR;
      bitcnt   <= '0;
      shreg    <= '0;
      remain   <= '0;
      idx      <= '0;
      ack_pend <= 1'b0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state    <= ST_BITS;
        phase    <= PH_ADDR;
        bitcnt   <= '0;
        ack_pend <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_BITS: if (scl_rise) begin
            shreg <= nb;
            if (bitcnt == 3'd7) begin
              bitcnt <= '0;
              state  <= ST_HOLD;
              case (phase)
                PH_ADDR: begin
                  ack_pend <= (nb == DEV_ADDR);
                  phase    <= PH_CMD;
                end
                PH_CMD: begin
                  ack_pend <= 1'b1;
                  phase    <= PH_CNT;
                end
                PH_CNT: begin
                  ack_pend <= 1'b1;
                  remain   <= nb;
                  idx      <= '0;
                  phase    <= PH_DATA;
                end
                default: begin
                  if (remain != 8'd0) begin
                    ack_pend <= 1'b1;
                    remain   <= remain - 8'd1;
                    if (idx < IDX_END) begin
                      wr_en   <= 1'b1;
                      wr_idx  <= idx[RIDX_W-1:0];
                      wr_data <= nb;
                      idx     <= idx + 1'b1;
                    end
                  end else begin
                    ack_pend <= 1'b0;
                  end
                end
              endcase
            end else begin
              bitcnt <= bitcnt + 3'd1;
            end
          end
          ST_HOLD: if (scl_fall) begin
            if (ack_pend) begin
              sda_oe <= 1'b1;
              state  <= ST_ACK;
            end else begin
              state <= ST_IGNORE;
            end
          end
          ST_ACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_BITS;
          end
          default: ;
        endcase
      end
    end
  end

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_q); // R10
  AST_START_NEW_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_BITS && phase == PH_ADDR && bitcnt == 3'd0)); // R9
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> (state == ST_IDLE && !sda_oe)); // R8
  AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE || state == ST_IDLE) |-> (!sda_oe && !wr_en)); // R3
  AST_WRITE_HAS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (state == ST_HOLD && ack_pend)); // R5
endmodule

// File: rtl/clkcfg_regfile.sv
module clkcfg_regfile #(
  parameter int  NUM_REGS = 4,
  parameter int  FS_W     = 3,
  localparam int RIDX_W   = $clog2(NUM_REGS),
  localparam int NGATE    = (NUM_REGS - 1) * 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [FS_W-1:0]       fs_strap,
  input  logic                  wr_en,
  input  logic [RIDX_W-1:0]     wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [NGATE-1:0]      clk_src,
  output logic [NUM_REGS*8-1:0] reg_flat,
  output logic [FS_W-1:0]       fs_sel,
  output logic [NGATE-1:0]      clk_gated
);
  logic [7:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] rst_val;
    if (g == 0) begin : g_fs
      assign rst_val = {{(8 - FS_W){1'b0}}, ~fs_strap};
    end else begin : g_en
      assign rst_val = 8'hFF;
      assign clk_gated[(g-1)*8 +: 8] = clk_src[(g-1)*8 +: 8] & regs[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             regs[g] <= rst_val;
      else if (wr_en && wr_idx == RIDX_W'(g)) regs[g] <= wr_data;
    end

    assign reg_flat[g*8 +: 8] = regs[g];

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_idx == RIDX_W'(g)) |=> $stable(regs[g])); // R5
  end

  assign fs_sel = regs[0][FS_W-1:0];
endmodule

// File: rtl/clkcfg_serial_slave.sv
module clkcfg_serial_slave #(
  parameter int         NUM_REGS    = 4,
  parameter int         FS_W        = 3,
  parameter logic [7:0] DEV_ADDR    = 8'hD2,
  parameter int         SYNC_STAGES = 2,
  localparam int        RIDX_W      = $clog2(NUM_REGS),
  localparam int        NGATE       = (NUM_REGS - 1) * 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl,
  input  logic                  sda_in,
  output logic                  sda_oe,
  input  logic [FS_W-1:0]       fs_strap,
  input  logic [NGATE-1:0]      clk_src,
  output logic [NUM_REGS*8-1:0] reg_flat,
  output logic [FS_W-1:0]       fs_sel,
  output logic [NGATE-1:0]      clk_gated
);
  logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [RIDX_W-1:0] wr_idx;
  logic [7:0]        wr_data;

  clkcfg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl), .sda_raw(sda_in),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  clkcfg_rx #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_rx (
    .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .sda_q(sda_q),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .sda_oe(sda_oe), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data)
  );

  clkcfg_regfile #(.NUM_REGS(NUM_REGS), .FS_W(FS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .fs_strap(fs_strap), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .clk_src(clk_src),
    .reg_flat(reg_flat), .fs_sel(fs_sel), .clk_gated(clk_gated)
  );

  AST_FS_TRACKS_REG0: assert property (@(posedge clk) disable iff (!rst_n)
    fs_sel == reg_flat[FS_W-1:0]); // R12
endmodule

// File: tb/clkcfg_serial_slave_bench.sv
module clkcfg_serial_slave_bench;
  localparam int NR = 4;
  localparam int FSW = 3;
  localparam int NG = (NR - 1) * 8;
  localparam int H = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, scl, sda_host, sda_oe, sda_line;
  logic [FSW-1:0] strap;
  logic [NG-1:0] clk_src, clk_gated;
  logic [NR*8-1:0] reg_flat;
  logic [FSW-1:0] fs_sel;
  assign sda_line = sda_host & ~sda_oe;

  clkcfg_serial_slave u_clkcfg_serial_slave (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda_in(sda_line), .sda_oe(sda_oe),
    .fs_strap(strap), .clk_src(clk_src), .reg_flat(reg_flat),
    .fs_sel(fs_sel), .clk_gated(clk_gated)
  );

  int checks = 0, fails = 0, oe_viol = 0;
  bit finished = 0;
  logic [7:0] model [NR];
  logic prev_oe = 1'b0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R10 monitor: sda_oe may only move while the raw bus clock is low
  always @(negedge clk) begin
    if (rst_n && scl && (sda_oe != prev_oe)) oe_viol++;
    prev_oe <= sda_oe;
  end

  task automatic bus_start();
    wt(H/2); sda_host = 1'b1; wt(H/2); scl = 1'b1; wt(H/2);
    sda_host = 1'b0; wt(H/2); scl = 1'b0;
  endtask

  task automatic bus_stop();
    wt(H/2); sda_host = 1'b0; wt(H/2); scl = 1'b1; wt(H/2);
    sda_host = 1'b1; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      wt(H/2); sda_host = b[i]; wt(H/2); scl = 1'b1; wt(H); scl = 1'b0;
    end
    wt(H/2); sda_host = 1'b1; wt(H/2); scl = 1'b1; wt(H/2);
    ack = ~sda_line;
    wt(H/2); scl = 1'b0;
  endtask

  function automatic logic [NR*8-1:0] model_flat();
    logic [NR*8-1:0] f;
    for (int g = 0; g < NR; g++) f[g*8 +: 8] = model[g];
    return f;
  endfunction

  function automatic logic [NG-1:0] exp_gate(input logic [NG-1:0] src);
    logic [NG-1:0] e;
    for (int i = 0; i < NG; i++) e[i] = src[i] & model[1 + i/8][i%8];
    return e;
  endfunction

  task automatic check_regs(input string req);
    wt(4);
    check(reg_flat == model_flat(), req, reg_flat, model_flat());
    check(fs_sel == model[0][FSW-1:0], "R12 fs_sel", fs_sel, model[0][FSW-1:0]);
  endtask

  // full write: address, command, count, nsend data bytes, then stop
  task automatic write_txn(input logic [7:0] addr, input logic [7:0] cnt, input int nsend);
    bit ack;
    logic [7:0] d;
    bit match = (addr == 8'hD2);
    bus_start();
    send_byte(addr, ack);
    check(ack == match, match ? "R2 address ack" : "R3 address nack", ack, match);
    send_byte($urandom_range(0, 255), ack);
    check(ack == match, match ? "R4 command ack" : "R3 ignored command", ack, match);
    send_byte(cnt, ack);
    check(ack == match, "R5 count ack", ack, match);
    for (int k = 0; k < nsend; k++) begin
      d = $urandom_range(0, 255);
      send_byte(d, ack);
      if (!match) check(ack == 1'b0, "R3 ignored data", ack, 0);
      else if (k < cnt) begin
        check(ack == 1'b1, k < NR ? "R5 data ack" : "R6 surplus ack", ack, 1);
        if (k < NR) model[k] = d;
      end else check(ack == 1'b0, "R7 over count nack", ack, 0);
    end
    bus_stop();
  endtask

  initial begin
    bit ack;
    logic [NG-1:0] src;
    void'($urandom(32'h5EED_0042));
    strap = 3'b101; scl = 1'b1; sda_host = 1'b1; clk_src = '0; rst_n = 1'b0;
    wt(5); rst_n = 1'b1; wt(4);

    model[0] = {5'b0, ~strap};
    for (int g = 1; g < NR; g++) model[g] = 8'hFF;
    check(reg_flat == model_flat(), "R1 reset registers", reg_flat, model_flat());
    check(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
    check(fs_sel == 3'b010, "R12 reset fs_sel", fs_sel, 3'b010);

    // directed: exact fill, surplus beyond file, over count
    write_txn(8'hD2, 8'd4, 4);   check_regs("R5 exact fill");
    write_txn(8'hD2, 8'd6, 6);   check_regs("R6 surplus discarded");
    write_txn(8'hD2, 8'd1, 3);   check_regs("R7 over count discarded");
    write_txn(8'hD0, 8'd4, 4);   check_regs("R3 wrong address");
    write_txn(8'hD3, 8'd2, 2);   check_regs("R3 read-bit address");

    // R8: pulses after stop without start
    send_byte(8'hD2, ack); check(ack == 1'b0, "R8 no ack after stop", ack, 0);
    send_byte(8'h00, ack); check(ack == 1'b0, "R8 no ack after stop", ack, 0);
    check_regs("R8 registers untouched");

    // R9: repeated start mid-count, then wrong address
    bus_start();
    send_byte(8'hD2, ack); check(ack, "R2 address ack", ack, 1);
    send_byte(8'h33, ack); check(ack, "R4 command ack", ack, 1);
    send_byte(8'd3, ack);  check(ack, "R5 count ack", ack, 1);
    send_byte(8'hA5, ack); check(ack, "R5 data ack", ack, 1); model[0] = 8'hA5;
    bus_start();
    send_byte(8'h52, ack); check(ack == 1'b0, "R9 new address phase", ack, 0);
    send_byte(8'h5A, ack); check(ack == 1'b0, "R9 old count dropped", ack, 0);
    bus_stop();
    check_regs("R9 repeated start");

    // random transactions
    for (int t = 0; t < 24; t++) begin
      logic [7:0] a = ($urandom_range(0, 7) == 0) ? 8'hD2 ^ (8'h1 << $urandom_range(0, 7)) : 8'hD2;
      write_txn(a, $urandom_range(0, 6), $urandom_range(0, 7));
      check_regs("R5 random transaction");
      for (int r = 0; r < 3; r++) begin
        src = {$urandom, $urandom};
        clk_src = src; wt(1);
        check(clk_gated == exp_gate(src), "R11 gating", clk_gated, exp_gate(src));
      end
    end
    clk_src = '1; wt(1);
    check(clk_gated == exp_gate('1), "R11 all sources high", clk_gated, exp_gate('1));

    check(oe_viol == 0, "R10 sda_oe moved with SCL high", oe_viol, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule